// File: doc/BRIEF.md
# Banked Analog-Output Host Register Interface

This block is the host-side register file of a multichannel analog-output card. It sits behind a 16-bit I/O bus and decodes byte offsets inside a 32-byte window. It holds three configuration words and a read-only status word. It also holds a 12-bit data latch for each DAC channel and an 8-bit digital I/O latch whose two nibbles each have their own output enable. It produces the strobes for the FIFO and for the counter/timer, which are outside the block.

Bit 7 of the first configuration word selects a second register bank. While that bank is selected, writes to the three lowest word offsets do not reach their registers. Each of these writes instead pulses a clear for one sticky flag: the DMA terminal-count flag, interrupt 1 or interrupt 2. Offset 0x0C does several jobs. A read of it clears the FIFO. A write to it pushes a FIFO word while bank 1 is selected, and loads DAC channel 0 while bank 2 is selected. The status word is read from the same offset at which configuration word 1 is written.

Top module: `aout_host_regs`

## Requirements
- R1: After a synchronous active-low reset, all three configuration words are 0. Bank 1 is selected, all sticky flags are clear, the DIO latch is 0 and both DIO nibbles are inputs.
- R2: A write to 0x02 or 0x04 in bank 1 loads configuration word 2 or 3, and a read of that offset returns the stored value. A write to 0x0A in either bank loads configuration word 1, which is driven on `cfg1_q`.
- R3: A read of 0x0A returns the status word. Bit 6 is FIFO half, bit 5 FIFO empty, bit 4 FIFO full, bit 3 interrupt 2, bit 2 interrupt 1, bit 1 terminal-count flag and bit 0 PROM data. Bits 15:7 read 0.
- R4: Each flag is set on a cycle in which one of its events occurs with that event's enable bit set in configuration word 1. Interrupt 2 uses bit 15 (external) and bit 13 (counter). Interrupt 1 uses bit 14 (external) and bit 12 (counter). The terminal-count flag uses bit 11. An event whose enable bit is clear leaves the flag unchanged. A set flag stays set while events are absent, until it is cleared.
- R5: With configuration word 1 bit 7 set, a write to 0x00 clears the terminal-count flag, a write to 0x02 clears interrupt 1 and a write to 0x04 clears interrupt 2. These writes leave the DIO latch and configuration words 2 and 3 unchanged. An event in the same cycle as a clear wins, and the flag stays set. In bank 1, writes to these offsets clear no flag.
- R6: A write to 0x0C in bank 1 pulses `fifo_wr` in that cycle and leaves DAC channel 0 unchanged. The same write in bank 2 loads DAC channel 0 and does not pulse `fifo_wr`. A read of 0x0C pulses `fifo_clr` and returns 0.
- R7: A write to 0x0C + 2n, for 1 ≤ n < N_CHAN, loads wdata[11:0] into DAC channel n in either bank. The value is a two's-complement code held as written, and wdata[15:12] is dropped. A DAC load pulses bit n of `dac_load` and changes no other channel.
- R8: A write to 0x00 in bank 1 loads the DIO latch from wdata[7:0]. `dio_oe[3:0]` follows configuration word 3 bit 2 and `dio_oe[7:4]` follows bit 3. A read of 0x00 returns the live pin inputs in bits 7:0, whether or not a nibble is driven.
- R9: Accesses to 0x06 and 0x08 reach the counter block. A read pulses `ctr_rd` and returns `ctr_rdata`. A write pulses `ctr_wr` in bank 1 only. `ctr_word` is 0 for 0x06 and 1 for 0x08.
- R10: Odd offsets and the write-only DAC offsets 0x0E and above read 0. A write to an odd offset changes no register and pulses no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Byte offset inside the window |
| wr_en | input | 1 | Write cycle |
| rd_en | input | 1 | Read cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current offset |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| prom_dout | input | 1 | Serial PROM data bit |
| ext1_evt | input | 1 | External interrupt 1 event |
| ext2_evt | input | 1 | External interrupt 2 event |
| cnt1_evt | input | 1 | Counter 1 interrupt event |
| cnt2_evt | input | 1 | Counter 2 interrupt event |
| tc_evt | input | 1 | DMA terminal-count event |
| ctr_rdata | input | 16 | Counter block read data |
| ctr_wr | output | 1 | Counter block write strobe |
| ctr_rd | output | 1 | Counter block read strobe |
| ctr_word | output | 1 | Counter word select |
| fifo_wr | output | 1 | FIFO push strobe (data is wdata) |
| fifo_clr | output | 1 | FIFO clear strobe |
| cfg1_q | output | 16 | Configuration word 1 |
| cfg2_q | output | 16 | Configuration word 2 |
| cfg3_q | output | 16 | Configuration word 3 |
| dac_load | output | N_CHAN | Per-channel DAC load strobe |
| dac_data | output | 12*N_CHAN | DAC channel latches, channel n at [12n +: 12] |
| dio_pin_in | input | 8 | Live DIO pin levels |
| dio_out | output | 8 | DIO output latch |
| dio_oe | output | 8 | DIO output enables |

## Verification
Offset 0x0C is written once in each bank. Comparing `fifo_wr` with DAC channel 0 shows whether bank selection steers the write. The same data pattern goes to 0x00/0x02/0x04 in both banks. This separates a register write from a flag clear, and shows whether a clear touches the registers behind it. Each flag event is sent first with its enable bit clear and then with it set, once with a clear in the same cycle and once again after the event has gone away. These passes show whether the enable gates the event, whether set beats clear, and whether the flag holds. The DIO pins are driven with a pattern that differs from the latch, so a read that returns the latch instead of the pins shows up.

// File: rtl/aoh_pkg.sv
// Package aoh_pkg
// Purpose : word offsets and bit positions shared by the host register block.
// Assumes : 16-bit bus; word index = byte offset >> 1 inside a 32-byte window.
package aoh_pkg;
    localparam int ADDR_W  = 5;
    localparam int WORD_W  = ADDR_W - 1;
    localparam int DATA_W  = 16;
    localparam int DAC_W   = 12;
    localparam int DIO_W   = 8;

    // Word indices
    localparam logic [WORD_W-1:0] W_DIO   = 4'd0;
    localparam logic [WORD_W-1:0] W_CFG2  = 4'd1;
    localparam logic [WORD_W-1:0] W_CFG3  = 4'd2;
    localparam logic [WORD_W-1:0] W_CTR0  = 4'd3;
    localparam logic [WORD_W-1:0] W_CTR1  = 4'd4;
    localparam logic [WORD_W-1:0] W_CFG1  = 4'd5;
    localparam logic [WORD_W-1:0] W_FIFO  = 4'd6;

    // Configuration word 1 bits
    localparam int C1_EXT2_EN = 15;
    localparam int C1_EXT1_EN = 14;
    localparam int C1_CNT2_EN = 13;
    localparam int C1_CNT1_EN = 12;
    localparam int C1_TC_EN   = 11;
    localparam int C1_BANK2   = 7;

    // Configuration word 3 bits
    localparam int C3_OE_LO = 2;
    localparam int C3_OE_HI = 3;
endpackage

// File: rtl/aoh_decode.sv
// Module aoh_decode
// Purpose : turns offset, bank and access type into one-cycle strobes.
// Assumes : wr_en and rd_en are never high together; strobes are combinational
//           and valid for the cycle of the access.
module aoh_decode #(
    parameter int N_CHAN = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [aoh_pkg::ADDR_W-1:0] addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic                      bank2,
    output logic                      wr_dio,
    output logic                      wr_cfg2,
    output logic                      wr_cfg3,
    output logic                      wr_cfg1,
    output logic                      clr_tc,
    output logic                      clr_i1,
    output logic                      clr_i2,
    output logic                      ctr_wr,
    output logic                      ctr_rd,
    output logic                      ctr_word,
    output logic                      fifo_wr,
    output logic                      fifo_clr,
    output logic [N_CHAN-1:0]         dac_we
);
    import aoh_pkg::*;

    logic [WORD_W-1:0] word;
    logic              wa, ra, is_ctr;

    // Purpose: split the byte offset into word index and alignment-gated access.
    always_comb begin
        word   = addr[ADDR_W-1:1];
        wa     = wr_en & ~addr[0];
        ra     = rd_en & ~addr[0];
        is_ctr = (word == W_CTR0) || (word == W_CTR1);
    end

    // Purpose: fixed-register strobes, bank 1 writes versus bank 2 clears.
    always_comb begin
        wr_dio   = wa & ~bank2 & (word == W_DIO);
        wr_cfg2  = wa & ~bank2 & (word == W_CFG2);
        wr_cfg3  = wa & ~bank2 & (word == W_CFG3);
        clr_tc   = wa &  bank2 & (word == W_DIO);
        clr_i1   = wa &  bank2 & (word == W_CFG2);
        clr_i2   = wa &  bank2 & (word == W_CFG3);
        wr_cfg1  = wa & (word == W_CFG1);
        ctr_wr   = wa & ~bank2 & is_ctr;
        ctr_rd   = ra & is_ctr;
        ctr_word = (word == W_CTR1);
        fifo_wr  = wa & ~bank2 & (word == W_FIFO);
        fifo_clr = ra & (word == W_FIFO);
    end

    // Purpose: per-channel DAC load strobes; channel 0 shares the FIFO offset.
    for (genvar n = 0; n < N_CHAN; n++) begin : g_dac
        if (n == 0) begin : g_ch0
            assign dac_we[n] = wa & bank2 & (word == W_FIFO);
        end else begin : g_chn
            assign dac_we[n] = wa & (word == W_FIFO + WORD_W'(n));
        end
    end

    // R6: a single write never both pushes the FIFO and loads a DAC.
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, dac_we}));
    // R5: a bank-2 clear never coincides with the register write it replaces.
    p_bank_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((clr_tc || clr_i1 || clr_i2) && (wr_dio || wr_cfg2 || wr_cfg3)));
endmodule

// File: rtl/aoh_flags.sv
// Module aoh_flags
// Purpose : three sticky event flags with per-source enables and clear strobes.
// Assumes : event and clear in the same cycle resolves to set.
module aoh_flags (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg1,
    input  logic        ext1_evt,
    input  logic        ext2_evt,
    input  logic        cnt1_evt,
    input  logic        cnt2_evt,
    input  logic        tc_evt,
    input  logic        clr_tc,
    input  logic        clr_i1,
    input  logic        clr_i2,
    output logic        tc_flag,
    output logic        i1_flag,
    output logic        i2_flag
);
    import aoh_pkg::*;

    logic set_tc, set_i1, set_i2;

    // Purpose: gate each event with its enable bit.
    always_comb begin
        set_tc = tc_evt & cfg1[C1_TC_EN];
        set_i1 = (ext1_evt & cfg1[C1_EXT1_EN]) | (cnt1_evt & cfg1[C1_CNT1_EN]);
        set_i2 = (ext2_evt & cfg1[C1_EXT2_EN]) | (cnt2_evt & cfg1[C1_CNT2_EN]);
    end

    // Purpose: sticky flags, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_flag <= 1'b0;
            i1_flag <= 1'b0;
            i2_flag <= 1'b0;
        end else begin
            tc_flag <= set_tc | (tc_flag & ~clr_tc);
            i1_flag <= set_i1 | (i1_flag & ~clr_i1);
            i2_flag <= set_i2 | (i2_flag & ~clr_i2);
        end
    end

    // R4: a set flag stays set without its clear.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (i1_flag && !clr_i1) |=> i1_flag);
    // R5: a clear without a same-cycle event drops the flag.
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i2 && !ext2_evt && !cnt2_evt) |=> !i2_flag);
    // R4: the terminal-count flag rises only after an event.
    p_tc_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> $past(tc_evt));
endmodule

// File: rtl/aoh_dio.sv
// Module aoh_dio
// Purpose : 8-bit digital output latch with per-nibble output enables.
// Assumes : pin read-back is done by the parent from the live pin inputs.
module aoh_dio (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [aoh_pkg::DIO_W-1:0] wdata,
    input  logic                     en_lo,
    input  logic                     en_hi,
    output logic [aoh_pkg::DIO_W-1:0] dio_out,
    output logic [aoh_pkg::DIO_W-1:0] dio_oe
);
    import aoh_pkg::*;
    localparam int HALF = DIO_W / 2;

    // Purpose: output latch loaded by a bank-1 write.
    always_ff @(posedge clk) begin
        if (!rst_n)  dio_out <= '0;
        else if (wr) dio_out <= wdata;
    end

    // Purpose: expand nibble enables to per-line enables.
    always_comb dio_oe = {{HALF{en_hi}}, {HALF{en_lo}}};

    // R8: the latch holds unless written.
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(dio_out));
endmodule

// File: rtl/aout_host_regs.sv
// Module aout_host_regs
// Purpose : host register window of a multichannel analog-output card:
//           configuration words, status, DAC latches, DIO, FIFO and counter
//           strobes, and a bank-2 view that turns low writes into flag clears.
// Assumes : one access per cycle, rdata is combinational for the current addr,
//           N_CHAN <= 10 so every DAC offset fits the 32-byte window.
module aout_host_regs #(
    parameter int N_CHAN = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [4:0]                    addr,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [15:0]                   wdata,
    output logic [15:0]                   rdata,
    input  logic                          fifo_half,
    input  logic                          fifo_empty,
    input  logic                          fifo_full,
    input  logic                          prom_dout,
    input  logic                          ext1_evt,
    input  logic                          ext2_evt,
    input  logic                          cnt1_evt,
    input  logic                          cnt2_evt,
    input  logic                          tc_evt,
    input  logic [15:0]                   ctr_rdata,
    output logic                          ctr_wr,
    output logic                          ctr_rd,
    output logic                          ctr_word,
    output logic                          fifo_wr,
    output logic                          fifo_clr,
    output logic [15:0]                   cfg1_q,
    output logic [15:0]                   cfg2_q,
    output logic [15:0]                   cfg3_q,
    output logic [N_CHAN-1:0]             dac_load,
    output logic [N_CHAN*12-1:0]          dac_data,
    input  logic [7:0]                    dio_pin_in,
    output logic [7:0]                    dio_out,
    output logic [7:0]                    dio_oe
);
    import aoh_pkg::*;

    logic wr_dio, wr_cfg1, wr_cfg2, wr_cfg3;
    logic clr_tc, clr_i1, clr_i2;
    logic tc_flag, i1_flag, i2_flag;
    logic [15:0] status;

    aoh_decode #(.N_CHAN(N_CHAN)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .bank2(cfg1_q[C1_BANK2]),
        .wr_dio(wr_dio), .wr_cfg2(wr_cfg2), .wr_cfg3(wr_cfg3), .wr_cfg1(wr_cfg1),
        .clr_tc(clr_tc), .clr_i1(clr_i1), .clr_i2(clr_i2),
        .ctr_wr(ctr_wr), .ctr_rd(ctr_rd), .ctr_word(ctr_word),
        .fifo_wr(fifo_wr), .fifo_clr(fifo_clr), .dac_we(dac_load)
    );

    aoh_flags u_flags (
        .clk(clk), .rst_n(rst_n), .cfg1(cfg1_q),
        .ext1_evt(ext1_evt), .ext2_evt(ext2_evt),
        .cnt1_evt(cnt1_evt), .cnt2_evt(cnt2_evt), .tc_evt(tc_evt),
        .clr_tc(clr_tc), .clr_i1(clr_i1), .clr_i2(clr_i2),
        .tc_flag(tc_flag), .i1_flag(i1_flag), .i2_flag(i2_flag)
    );

    aoh_dio u_dio (
        .clk(clk), .rst_n(rst_n), .wr(wr_dio), .wdata(wdata[DIO_W-1:0]),
        .en_lo(cfg3_q[C3_OE_LO]), .en_hi(cfg3_q[C3_OE_HI]),
        .dio_out(dio_out), .dio_oe(dio_oe)
    );

    // Purpose: configuration words; reset returns to bank 1 with enables off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_q <= '0;
            cfg2_q <= '0;
            cfg3_q <= '0;
        end else begin
            if (wr_cfg1) cfg1_q <= wdata;
            if (wr_cfg2) cfg2_q <= wdata;
            if (wr_cfg3) cfg3_q <= wdata;
        end
    end

    // Purpose: per-channel DAC latches holding two's-complement codes.
    for (genvar n = 0; n < N_CHAN; n++) begin : g_dac
        always_ff @(posedge clk) begin
            if (!rst_n)           dac_data[n*DAC_W +: DAC_W] <= '0;
            else if (dac_load[n]) dac_data[n*DAC_W +: DAC_W] <= wdata[DAC_W-1:0];
        end
    end

    // Purpose: assemble the status word.
    always_comb status = {9'd0, fifo_half, fifo_empty, fifo_full,
                          i2_flag, i1_flag, tc_flag, prom_dout};

    // Purpose: read multiplexer; odd and write-only offsets return 0.
    always_comb begin
        rdata = '0;
        if (!addr[0]) begin
            unique case (addr[4:1])
                W_DIO:          rdata = {8'd0, dio_pin_in};
                W_CFG2:         rdata = cfg2_q;
                W_CFG3:         rdata = cfg3_q;
                W_CTR0, W_CTR1: rdata = ctr_rdata;
                W_CFG1:         rdata = status;
                default:        rdata = '0;
            endcase
        end
    end

    // R1: reset leaves bank 1 selected with all enables off.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg1_q == 16'd0 && cfg3_q == 16'd0));
    // R7: a DAC latch moves only on its load strobe.
    p_dac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load[1] |=> $stable(dac_data[DAC_W +: DAC_W]));
    // R2: configuration word 2 is untouched in bank 2.
    p_cfg2_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg1_q[C1_BANK2] |=> $stable(cfg2_q));
endmodule

// File: tb/aout_host_regs_tb.sv
module aout_host_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic fifo_half = 0, fifo_empty = 0, fifo_full = 0, prom_dout = 0;
    logic ext1_evt = 0, ext2_evt = 0, cnt1_evt = 0, cnt2_evt = 0, tc_evt = 0;
    logic [15:0] ctr_rdata = 16'hC0DE;
    logic ctr_wr, ctr_rd, ctr_word, fifo_wr, fifo_clr;
    logic [15:0] cfg1_q, cfg2_q, cfg3_q;
    logic [NCH-1:0] dac_load;
    logic [NCH*12-1:0] dac_data;
    logic [7:0] dio_pin_in = '0, dio_out, dio_oe;

    int errors = 0, checks = 0;
    logic [NCH-1:0] o_dac;
    logic o_fifo_wr, o_fifo_clr, o_ctr_wr, o_ctr_rd, o_ctr_word;
    logic [15:0] o_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    aout_host_regs #(.N_CHAN(NCH)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; strobes and read data captured before the active edge.
    task automatic acc(input logic w, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; rd_en = ~w;
        #1;
        o_dac = dac_load; o_fifo_wr = fifo_wr; o_fifo_clr = fifo_clr;
        o_ctr_wr = ctr_wr; o_ctr_rd = ctr_rd; o_ctr_word = ctr_word; o_rdata = rdata;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d); acc(1'b1, a, d); endtask
    task automatic rd(input logic [4:0] a); acc(1'b0, a, 16'h0); endtask

    function automatic logic [11:0] ch(input int n); return dac_data[n*12 +: 12]; endfunction

    task automatic t_reset;
        chk("R1 cfg1", cfg1_q, 0); chk("R1 cfg2", cfg2_q, 0); chk("R1 cfg3", cfg3_q, 0);
        chk("R1 dio_out", dio_out, 0); chk("R1 dio_oe", dio_oe, 0);
        rd(5'h0A); chk("R1 flags clear", o_rdata[3:1], 0);
    endtask

    task automatic t_cfg;
        wr(5'h02, 16'hA5C3); rd(5'h02); chk("R2 cfg2 readback", o_rdata, 16'hA5C3);
        wr(5'h04, 16'h0004); rd(5'h04); chk("R2 cfg3 readback", o_rdata, 16'h0004);
        wr(5'h0A, 16'h0123); chk("R2 cfg1 drive", cfg1_q, 16'h0123);
        wr(5'h0A, 16'h0000);
    endtask

    task automatic t_status;
        fifo_half = 1; fifo_empty = 0; fifo_full = 1; prom_dout = 1;
        rd(5'h0A); chk("R3 status 0x51", o_rdata, 16'h0051);
        fifo_half = 0; fifo_empty = 1; fifo_full = 0; prom_dout = 0;
        rd(5'h0A); chk("R3 status 0x20", o_rdata, 16'h0020);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1; @(negedge clk); s = 0;
    endtask

    task automatic t_irq;
        pulse(ext1_evt); pulse(tc_evt); pulse(cnt2_evt);
        rd(5'h0A); chk("R4 disabled events ignored", o_rdata[3:1], 3'b000);
        wr(5'h0A, 16'h5800);  // ext1, cnt1? no: bits14,12,11
        pulse(ext1_evt); pulse(tc_evt);
        rd(5'h0A); chk("R4 enabled set", o_rdata[3:1], 3'b011);
        repeat (3) @(negedge clk);
        rd(5'h0A); chk("R4 sticky", o_rdata[3:1], 3'b011);
        wr(5'h0A, 16'hA000); pulse(cnt2_evt);
        rd(5'h0A); chk("R4 cnt2 sets int2", o_rdata[3:1], 3'b111);
        wr(5'h02, 16'h1111);
        rd(5'h0A); chk("R5 bank1 no clear", o_rdata[3:1], 3'b111);
    endtask

    task automatic t_bank2;
        wr(5'h0A, 16'h2080);  // bank2, cnt2 enabled
        wr(5'h02, 16'hFFFF);
        rd(5'h0A); chk("R5 clear int1", o_rdata[3:1], 3'b101);
        wr(5'h00, 16'h00FF);
        rd(5'h0A); chk("R5 clear tc", o_rdata[3:1], 3'b100);
        @(negedge clk); addr = 5'h04; wdata = 16'hFFFF; wr_en = 1; cnt2_evt = 1;
        @(negedge clk); wr_en = 0; cnt2_evt = 0;
        rd(5'h0A); chk("R5 set beats clear", o_rdata[3:1], 3'b100);
        wr(5'h04, 16'hFFFF);
        rd(5'h0A); chk("R5 clear int2", o_rdata[3:1], 3'b000);
        chk("R5 cfg2 kept", cfg2_q, 16'h1111);
        chk("R5 cfg3 kept", cfg3_q, 16'h0004);
        chk("R5 dio kept", dio_out, 8'h00);
    endtask

    task automatic t_fifo_dac0;
        wr(5'h0A, 16'h0000);
        wr(5'h0C, 16'h0ABC);
        chk("R6 bank1 fifo_wr", o_fifo_wr, 1); chk("R6 bank1 no dac0", ch(0), 0);
        wr(5'h0A, 16'h0080);
        wr(5'h0C, 16'h07FF);
        chk("R6 bank2 no fifo_wr", o_fifo_wr, 0); chk("R6 bank2 dac0", ch(0), 12'h7FF);
        rd(5'h0C); chk("R6 fifo_clr", o_fifo_clr, 1); chk("R6 read zero", o_rdata, 0);
    endtask

    task automatic t_dac;
        wr(5'h0E, 16'hF800);
        chk("R7 ch1 load strobe", o_dac, 10'b0000000010);
        chk("R7 ch1 value", ch(1), 12'h800);
        wr(5'h0A, 16'h0000);
        wr(5'h1E, 16'h0123);
        chk("R7 ch9 value", ch(9), 12'h123);
        chk("R7 others untouched", {ch(0), ch(1)}, {12'h7FF, 12'h800});
        for (int n = 2; n < 9; n++) chk("R7 idle ch", ch(n), 0);
    endtask

    task automatic t_dio;
        wr(5'h00, 16'hFF3C); chk("R8 latch", dio_out, 8'h3C);
        chk("R8 oe lo only", dio_oe, 8'h0F);
        wr(5'h04, 16'h0008); chk("R8 oe hi only", dio_oe, 8'hF0);
        dio_pin_in = 8'hA5;
        rd(5'h00); chk("R8 pins read", o_rdata, 16'h00A5);
    endtask

    task automatic t_ctr;
        wr(5'h06, 16'h0034); chk("R9 ctr_wr", o_ctr_wr, 1); chk("R9 word0", o_ctr_word, 0);
        rd(5'h08); chk("R9 ctr_rd", o_ctr_rd, 1); chk("R9 word1", o_ctr_word, 1);
        chk("R9 read data", o_rdata, 16'hC0DE);
        wr(5'h0A, 16'h0080);
        wr(5'h06, 16'h0034); chk("R9 bank2 no ctr_wr", o_ctr_wr, 0);
        wr(5'h0A, 16'h0000);
    endtask

    task automatic t_undec;
        rd(5'h03); chk("R10 odd reads 0", o_rdata, 0);
        rd(5'h10); chk("R10 dac offset reads 0", o_rdata, 0);
        wr(5'h03, 16'hBEEF); chk("R10 odd write cfg", cfg2_q, 16'h1111);
        wr(5'h0D, 16'hBEEF);
        chk("R10 odd write no strobe", {o_fifo_wr, o_dac}, 0);
        chk("R10 odd write cfg3", cfg3_q, 16'h0008);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_cfg; t_status; t_irq; t_bank2;
        t_fifo_dac0; t_dac; t_dio; t_ctr; t_undec;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule